// File: doc/BRIEF.md
# Sample Stream Output Demultiplexer

The block takes one 8-bit offset-binary sample per clock and spreads the samples over four parallel output buses named A, B, C and D. In the wide mode each bus takes every fourth sample. All four buses load on the same clock edge, once per group of four samples. A mode input selects a narrow mode in which only buses C and D carry data, each taking every second sample. Buses A and B then hold the mid-scale code.

Alongside the data the block produces a data clock for the receiver. It can be single-rate, with one period per group, or double-rate, toggling once per group. In double-rate operation its edges either line up with the data updates or fall halfway between them. The sample stream can be replaced by a counting test pattern that gives each bus its own offset, so that a receiver can spot swapped or stuck buses. A valid flag marks the bus contents as a complete group. A change of mode drops the flag and starts a new group.

Top module: `sample_demux`

## Requirements
- R1: During and directly after a synchronous reset (rst_n low at a clock edge), all four buses read 0x80, valid_o is 0 and dclk_o is 0.
- R2: In wide mode (half_mode_i = 0), the four samples of a group land oldest to newest on D, C, B, A. All four buses load on the edge that captures the fourth sample, so they update once every four clocks.
- R3: In narrow mode (half_mode_i = 1), a group is two samples: the older goes to D and the newer to C. Buses A and B read the mid-scale code 0x80 after every group load.
- R4: valid_o is 0 from reset until the first complete group loads. It is 1 from that load on, as long as the mode does not change.
- R5: An edge at which half_mode_i differs from the mode in use is a mode change. It discards the sample presented at that edge, drops valid_o to 0 and restarts the group count, so the next complete group is formed from the samples that follow, in the new mode.
- R6: With ddr_i = 0, dclk_o goes high on each group load edge. It stays high for the first half of the group period and low for the second half.
- R7: With ddr_i = 1 and ph90_i = 0, dclk_o toggles on every group load edge.
- R8: With ddr_i = 1 and ph90_i = 1, dclk_o toggles on the edge halfway between group loads: two clocks after a load in wide mode, one clock after a load in narrow mode.
- R9: With test_en_i = 1, a group load writes a pattern value g in place of the samples, where g counts group loads since test mode was entered, starting at 0. The buses read D = g, C = g + 0x40, B = g + 0x80 and A = g + 0xC0, all modulo 256. In narrow mode, A and B still read 0x80.
- R10: A clock edge with test_en_i = 0 clears the pattern count, so the next pattern group after re-enabling shows g = 0.
- R11: The buses keep their values between group loads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_i | input | 8 | Offset-binary input sample |
| half_mode_i | input | 1 | 1 selects narrow (two-bus) mode |
| ddr_i | input | 1 | 1 selects a double-rate data clock |
| ph90_i | input | 1 | In double-rate mode, 1 moves the clock edges to mid-group |
| test_en_i | input | 1 | 1 replaces samples with the test pattern |
| bus_a_o | output | 8 | Bus A, newest sample of a wide group |
| bus_b_o | output | 8 | Bus B |
| bus_c_o | output | 8 | Bus C |
| bus_d_o | output | 8 | Bus D, oldest sample of a group |
| valid_o | output | 1 | Buses hold a complete group |
| dclk_o | output | 1 | Data clock for the receiver |

## Verification
The clock-shape properties take for granted that ddr_i and ph90_i stay constant while the block runs. The stimulus changes them only while reset is held. The mode-change property accepts a change of half_mode_i on any edge, and the directed test moves it mid-group on purpose. The bus-hold property relies on test_en_i changing only between groups or being cleared for a whole edge, which the pattern-restart test respects.

// File: rtl/sdm_pkg.sv
// Shared definitions for the sample demultiplexer.
// Assumes samples use offset-binary coding, so mid-scale is the top bit alone.
package sdm_pkg;

    typedef enum logic [1:0] {
        CK_SDR       = 2'd0,
        CK_DDR_ALIGN = 2'd1,
        CK_DDR_QUAD  = 2'd2
    } dclk_mode_e;

    // Mid-scale code of an offset-binary word of width w.
    function automatic int unsigned mid_code(input int unsigned w);
        return 32'd1 << (w - 1);
    endfunction

endpackage

// File: rtl/sdm_seq.sv
// Group sequencer: counts samples inside a group, flags the load edge and
// detects mode changes. Assumes LANES is a power of two and at least 4.
module sdm_seq #(
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_i,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          load,
    output logic          chg,
    output logic          half_q
);

    logic [CW-1:0] grp_last;

    // Decode group length, load edge and next count.
    always_comb begin
        grp_last = half_q ? CW'(LANES / 2 - 1) : CW'(LANES - 1);
        chg      = (half_i != half_q);
        load     = !chg && (cnt == grp_last);
        cnt_nxt  = (chg || load) ? '0 : cnt + 1'b1;
    end

    // Hold the count and the mode in use.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            half_q <= half_i;
        end else begin
            cnt    <= cnt_nxt;
            half_q <= half_i;
        end
    end

endmodule

// File: rtl/sdm_lanes.sv
// Lane storage: stages the samples of a group and loads every output bus
// together on the load edge. Also holds the test pattern count and the
// valid flag. Lane 0 is bus A (newest), lane LANES-1 is bus D (oldest).
// Assumes load and chg are never both high.
module sdm_lanes #(
    parameter int W     = 8,
    parameter int LANES = 4,
    localparam int CW   = $clog2(LANES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [W-1:0]              smp,
    input  logic [CW-1:0]             cnt,
    input  logic                      load,
    input  logic                      chg,
    input  logic                      half_q,
    input  logic                      test_en,
    output logic [LANES-1:0][W-1:0]   bus,
    output logic                      valid
);

    localparam logic [W-1:0] MID  = W'(sdm_pkg::mid_code(W));
    localparam int           STEP = (1 << W) / LANES;

    logic [W-1:0] tp;

    // Test pattern count: cleared while disabled, advanced per group load.
    always_ff @(posedge clk) begin
        if (!rst_n || !test_en) tp <= '0;
        else if (load)          tp <= tp + 1'b1;
    end

    // Valid flag: set by a group load, cleared by a mode change.
    always_ff @(posedge clk) begin
        if (!rst_n)    valid <= 1'b0;
        else if (chg)  valid <= 1'b0;
        else if (load) valid <= 1'b1;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam logic [CW-1:0] IDX    = CW'(LANES - 1 - l);
        localparam logic [W-1:0]  OFS    = W'((LANES - 1 - l) * STEP);
        localparam bit            NARROW = (l >= LANES / 2);

        logic [W-1:0] stage;
        logic         active;
        logic         mine;

        // Lane takes data in wide mode, or when it is one of the narrow lanes.
        always_comb begin
            active = !half_q || NARROW;
            mine   = (cnt == IDX);
        end

        // Stage this lane's sample until the group completes.
        always_ff @(posedge clk) begin
            if (!rst_n)                      stage <= MID;
            else if (!chg && !load && mine)  stage <= smp;
        end

        // Load the output bus on the group edge, otherwise hold.
        always_ff @(posedge clk) begin
            if (!rst_n)       bus[l] <= MID;
            else if (load) begin
                if (!active)      bus[l] <= MID;
                else if (test_en) bus[l] <= tp + OFS;
                else if (mine)    bus[l] <= smp;
                else              bus[l] <= stage;
            end
        end
    end

endmodule

// File: rtl/sdm_dclk.sv
// Data clock generator: derives the receiver clock from the group count.
// Single rate: high for the first half of each group. Double rate: toggles
// once per group, at the load edge or at mid-group.
module sdm_dclk #(
    parameter int LANES = 4,
    localparam int CW = $clog2(LANES)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [CW-1:0]          cnt_nxt,
    input  logic                   load,
    input  logic                   half_q,
    input  sdm_pkg::dclk_mode_e    mode,
    output logic                   dclk
);

    logic [CW-1:0] half_len;
    logic          dclk_nxt;

    // Choose the next clock level for the selected mode.
    always_comb begin
        half_len = half_q ? CW'(LANES / 4) : CW'(LANES / 2);
        unique case (mode)
            sdm_pkg::CK_DDR_ALIGN: dclk_nxt = load ? !dclk : dclk;
            sdm_pkg::CK_DDR_QUAD:  dclk_nxt = (cnt_nxt == half_len) ? !dclk : dclk;
            default:               dclk_nxt = (cnt_nxt < half_len);
        endcase
    end

    // Register the clock so that it leaves the block glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) dclk <= 1'b0;
        else        dclk <= dclk_nxt;
    end

endmodule

// File: rtl/sample_demux.sv
// Top level: four-bus sample demultiplexer with a two-bus mode, data clock
// generation and a test pattern source. The bus count is fixed at four by
// the named ports; the sample width is a parameter.
module sample_demux #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp_i,
    input  logic         half_mode_i,
    input  logic         ddr_i,
    input  logic         ph90_i,
    input  logic         test_en_i,
    output logic [W-1:0] bus_a_o,
    output logic [W-1:0] bus_b_o,
    output logic [W-1:0] bus_c_o,
    output logic [W-1:0] bus_d_o,
    output logic         valid_o,
    output logic         dclk_o
);

    localparam int LANES = 4;
    localparam int CW    = $clog2(LANES);

    logic [CW-1:0]            cnt;
    logic [CW-1:0]            cnt_nxt;
    logic                     load;
    logic                     chg;
    logic                     half_q;
    logic [LANES-1:0][W-1:0]  bus_w;
    sdm_pkg::dclk_mode_e      ck_mode;

    // Map the two clock-mode inputs onto one mode value.
    always_comb begin
        if (!ddr_i)      ck_mode = sdm_pkg::CK_SDR;
        else if (ph90_i) ck_mode = sdm_pkg::CK_DDR_QUAD;
        else             ck_mode = sdm_pkg::CK_DDR_ALIGN;
    end

    sdm_seq #(.LANES(LANES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .half_i  (half_mode_i),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt),
        .load    (load),
        .chg     (chg),
        .half_q  (half_q)
    );

    sdm_lanes #(.W(W), .LANES(LANES)) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp_i),
        .cnt     (cnt),
        .load    (load),
        .chg     (chg),
        .half_q  (half_q),
        .test_en (test_en_i),
        .bus     (bus_w),
        .valid   (valid_o)
    );

    sdm_dclk #(.LANES(LANES)) u_dclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_nxt (cnt_nxt),
        .load    (load),
        .half_q  (half_q),
        .mode    (ck_mode),
        .dclk    (dclk_o)
    );

    // Bring the lanes out on the named buses.
    always_comb begin
        bus_a_o = bus_w[0];
        bus_b_o = bus_w[1];
        bus_c_o = bus_w[2];
        bus_d_o = bus_w[3];
    end

endmodule

// File: rtl/sdm_chk.sv
// Property checker for sample_demux, attached by the bind below.
// Assumes ddr_i and ph90_i are held constant outside reset.
module sdm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         load,
    input logic         chg,
    input logic         half_q,
    input logic         ddr_i,
    input logic         ph90_i,
    input logic         valid_o,
    input logic         dclk_o,
    input logic [W-1:0] bus_a_o,
    input logic [W-1:0] bus_b_o,
    input logic [W-1:0] bus_c_o,
    input logic [W-1:0] bus_d_o
);

    localparam logic [W-1:0] MID = W'(sdm_pkg::mid_code(W));

    // R11
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(bus_a_o) && $stable(bus_b_o) &&
                   $stable(bus_c_o) && $stable(bus_d_o)));

    // R3
    narrow_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && half_q) |=> (bus_a_o == MID && bus_b_o == MID));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(load));

    // R5
    mode_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !valid_o);

    // R6
    sdr_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_i && load) |=> dclk_o);

    // R7
    ddr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr_i && !ph90_i && load) |=> (dclk_o != $past(dclk_o)));

endmodule

bind sample_demux sdm_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .chg     (chg),
    .half_q  (half_q),
    .ddr_i   (ddr_i),
    .ph90_i  (ph90_i),
    .valid_o (valid_o),
    .dclk_o  (dclk_o),
    .bus_a_o (bus_a_o),
    .bus_b_o (bus_b_o),
    .bus_c_o (bus_c_o),
    .bus_d_o (bus_d_o)
);

// File: tb/sim_sample_demux.sv
// Bench for sample_demux: a table of run configurations walked by one loop,
// each compared edge by edge against a model built from the requirements,
// followed by directed tests for mode change and pattern restart.
module sim_sample_demux;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] smp = 8'h00;
    logic       half = 1'b0;
    logic       ddr = 1'b0;
    logic       ph90 = 1'b0;
    logic       tst = 1'b0;
    logic [7:0] ba, bb, bc, bd;
    logic       vld, dck;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    sample_demux u0 (
        .clk(clk), .rst_n(rst_n), .smp_i(smp), .half_mode_i(half),
        .ddr_i(ddr), .ph90_i(ph90), .test_en_i(tst),
        .bus_a_o(ba), .bus_b_o(bb), .bus_c_o(bc), .bus_d_o(bd),
        .valid_o(vld), .dclk_o(dck)
    );

    // {half, ddr, ph90, test, seed[7:0], step[7:0]}
    localparam int NV = 7;
    localparam logic [19:0] VEC [NV] = '{
        {4'b0000, 8'h0A, 8'h03},
        {4'b0100, 8'hF0, 8'h01},
        {4'b0110, 8'h7F, 8'h11},
        {4'b1000, 8'h20, 8'h05},
        {4'b1110, 8'hFE, 8'h01},
        {4'b0001, 8'h00, 8'h00},
        {4'b1101, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    endtask

    // Reset with the given modes; check the reset state (R1).
    task automatic do_reset(input logic h, input logic d, input logic p, input logic t);
        @(negedge clk);
        half = h; ddr = d; ph90 = p; tst = t; rst_n = 1'b0;
        @(negedge clk);
        chk("R1 bus_a", ba, 8'h80);
        chk("R1 bus_b", bb, 8'h80);
        chk("R1 bus_c", bc, 8'h80);
        chk("R1 bus_d", bd, 8'h80);
        chk("R1 valid", {7'd0, vld}, 8'h00);
        chk("R1 dclk", {7'd0, dck}, 8'h00);
        rst_n = 1'b1;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        for (int v = 0; v < NV; v++) begin
            logic h, d, p, t;
            logic [7:0] seed, stp;
            int g;
            {h, d, p, t, seed, stp} = VEC[v];
            g = h ? 2 : 4;
            do_reset(h, d, p, t);
            smp = seed;
            for (int j = 0; j < 12; j++) begin
                int loads;
                logic [7:0] ed, ec, eb, ea;
                logic ek;
                @(negedge clk);
                loads = (j + 1) / g;
                if (loads == 0) begin
                    ea = 8'h80; eb = 8'h80; ec = 8'h80; ed = 8'h80;
                end else begin
                    int base;
                    int gi;
                    gi = loads - 1;
                    base = gi * g;
                    if (t) begin
                        ed = 8'(gi); ec = 8'(gi + 8'h40);
                        eb = 8'(gi + 8'h80); ea = 8'(gi + 8'hC0);
                    end else begin
                        ed = 8'(seed + stp * base);
                        ec = 8'(seed + stp * (base + 1));
                        eb = 8'(seed + stp * (base + 2));
                        ea = 8'(seed + stp * (base + 3));
                    end
                    if (h) begin
                        ea = 8'h80; eb = 8'h80;
                    end
                end
                // R2 R3 R9 R11: bus contents after each edge
                chk(h ? "R3 bus_a" : (t ? "R9 bus_a" : "R2 bus_a"), ba, ea);
                chk(h ? "R3 bus_b" : (t ? "R9 bus_b" : "R2 bus_b"), bb, eb);
                chk(t ? "R9 bus_c" : "R11 bus_c", bc, ec);
                chk(t ? "R9 bus_d" : "R11 bus_d", bd, ed);
                // R4
                chk("R4 valid", {7'd0, vld}, (loads > 0) ? 8'h01 : 8'h00);
                if (!d)      ek = (((j + 1) % g) < g / 2);
                else if (!p) ek = ((((j + 1) / g) % 2) == 1);
                else         ek = ((((j + 1 + g / 2) / g) % 2) == 1);
                chk(!d ? "R6 dclk" : (!p ? "R7 dclk" : "R8 dclk"), {7'd0, dck}, {7'd0, ek});
                smp = 8'(seed + stp * (j + 1));
            end
        end

        // R5: mode change in mid-group
        do_reset(1'b0, 1'b0, 1'b0, 1'b0);
        for (int j = 0; j < 6; j++) begin
            smp = 8'(8'h30 + j);
            @(negedge clk);
        end
        chk("R5 valid before change", {7'd0, vld}, 8'h01);
        half = 1'b1; smp = 8'hAA;
        @(negedge clk);
        chk("R5 valid after change", {7'd0, vld}, 8'h00);
        smp = 8'h11;
        @(negedge clk);
        chk("R5 valid mid group", {7'd0, vld}, 8'h00);
        smp = 8'h22;
        @(negedge clk);
        chk("R5 valid new group", {7'd0, vld}, 8'h01);
        chk("R5 bus_d", bd, 8'h11);
        chk("R5 bus_c", bc, 8'h22);
        chk("R3 bus_a", ba, 8'h80);
        chk("R3 bus_b", bb, 8'h80);

        // R10: pattern count restarts after test mode is cleared
        do_reset(1'b0, 1'b0, 1'b0, 1'b1);
        smp = 8'h55;
        for (int j = 0; j < 8; j++) @(negedge clk);
        chk("R10 bus_d before clear", bd, 8'h01);
        tst = 1'b0;
        @(negedge clk);
        tst = 1'b1;
        for (int j = 0; j < 3; j++) @(negedge clk);
        chk("R10 bus_d", bd, 8'h00);
        chk("R10 bus_c", bc, 8'h40);
        chk("R10 bus_b", bb, 8'h80);
        chk("R10 bus_a", ba, 8'hC0);

        summary();
        $finish;
    end

endmodule